// File: doc/BRIEF.md
# Flash Linear Window Sequencer

This block lets a host reach serial flash through ordinary memory accesses. Two windows exist, one for reads and one for writes. Each has four registers: a transfer configuration word, a control word (opcode, chip select, enable), a start address and a range length. While a window is enabled, a byte access at window offset `o` becomes a serial flash command to address `start + o`. The command goes out on a request port to a separate transfer engine, and read data comes back from that engine.

The sequencer keeps one command open across accesses. An access that continues where the previous one stopped, on the same window, sends only a data beat. Any other access closes the open command first: chip select goes high and the engine confirms, then a fresh command starts. Clearing a window's enable closes its open command. The status bit for that window is set only after the engine has confirmed that chip select is deasserted. Software polls that bit and clears it by writing a one before it reuses the interface.

Top module: `flash_linear_window`

## Requirements
- R1: After reset, every register reads zero, no command is presented (`cmd_valid` low) and no window acknowledge is given.
- R2: The read window's configuration, control, start and range registers sit at offsets 0x44, 0x48, 0x4C and 0x50. The write window's sit at 0x80, 0x84, 0x88 and 0x8C. Status is at 0x04. All of them read back what was written. In the control word, bit 31 is the enable, the chip select starts at bit 21 and the opcode is bits 7:0.
- R3: An accepted access at offset `o` issues a command start (`cmd_kind` 0) carrying the window's opcode, its chip select and address `start + o`, followed by a data beat (`cmd_kind` 1). A read returns the engine's byte on `win_rdata`. A write carries `win_wdata` on `cmd_wdata`.
- R4: The configuration word reaches `cmd_cfg` unchanged, except that bit 23 is forced to 1 for read-window commands and to 0 for write-window commands.
- R5: An access is answered with `win_err` together with `win_ack`, and issues no command of any kind, if its offset is at or beyond the range value or if its window is disabled.
- R6: An access whose `start + o` does not fit in 32 bits is answered with an error and issues no command.
- R7: An access on the same window whose address is exactly one above the previous data beat's address issues only a data beat, with no new command start.
- R8: Any other access while a command is open issues a close (`cmd_kind` 2). The sequencer waits for `eng_end_done` and then issues a new command start.
- R9: Writing a zero enable bit to a window that was enabled sets that window's status bit (bit 11 read, bit 12 write). If that window has a command open, the bit is set only after the close has been confirmed by `eng_end_done`. Otherwise it is set within a few cycles.
- R10: Status bits are cleared by writing 1 at their position. Writing 0 leaves them unchanged.
- R11: A presented command keeps `cmd_valid`, its kind and its address unchanged until `cmd_ready` accepts it.
- R12: Each window access is answered by a `win_ack` pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| win_req | input | 1 | Window access request, held until acknowledged |
| win_we | input | 1 | 1 selects the write window, 0 the read window |
| win_off | input | 32 | Byte offset inside the window |
| win_wdata | input | 8 | Write byte |
| win_ack | output | 1 | Access done, one-cycle pulse |
| win_err | output | 1 | Access rejected, valid with win_ack |
| win_rdata | output | 8 | Read byte, valid with win_ack |
| cmd_valid | output | 1 | Command presented to the transfer engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_kind | output | 2 | 0 start, 1 data beat, 2 close |
| cmd_cfg | output | 32 | Transfer configuration with direction bit fixed |
| cmd_opcode | output | 8 | Flash opcode |
| cmd_cs | output | CS_W | Chip select number |
| cmd_addr | output | 32 | Flash byte address |
| cmd_wdata | output | 8 | Write byte for a data beat |
| eng_rdata_valid | input | 1 | Engine returns a read byte |
| eng_rdata | input | 8 | Read byte from the engine |
| eng_end_done | input | 1 | Engine reports chip select deasserted after a close |

## Verification
The embedded assertions watch properties that hold on every cycle. They check that a presented command stays stable under backpressure and that data beats appear only inside an open command. They check that a command start never appears while another is open, and that an acknowledge lasts one cycle. They also check that a status bit never rises while its window still holds chip select, and that a write-one clears it. Only the directed scenarios can show which commands an access produces: the computed flash address, the forced direction bit, the rejection of out-of-range and overflowing offsets, and the choice between continuing and restarting a command. They also show that the completion flag waits for the engine's close confirmation rather than for the register write.

// File: rtl/lfw_pkg.sv
package lfw_pkg;
   typedef enum logic [1:0] {
      LFW_CMD_START = 2'd0,
      LFW_CMD_DATA  = 2'd1,
      LFW_CMD_END   = 2'd2
   } lfw_cmd_e;

   localparam int SIDE_RD = 0;
   localparam int SIDE_WR = 1;

   localparam logic [7:0] OFF_STATUS  = 8'h04;
   localparam logic [7:0] OFF_RD_BANK = 8'h44;
   localparam logic [7:0] OFF_WR_BANK = 8'h80;

   // register roles inside a bank, four bytes apart
   localparam int ROLE_CFG   = 0;
   localparam int ROLE_CTRL  = 1;
   localparam int ROLE_BASE  = 2;
   localparam int ROLE_RANGE = 3;

   localparam int CTRL_EN_BIT = 31;
   localparam int CTRL_CS_LSB = 21;
   localparam int CFG_DIR_BIT = 23;
   localparam int STS_RD_BIT  = 11;

   function automatic logic [7:0] bank_off(input int side, input int role);
      return ((side == SIDE_WR) ? OFF_WR_BANK : OFF_RD_BANK) + 8'(role * 4);
   endfunction
endpackage

// File: rtl/lfw_regs.sv
module lfw_regs
   import lfw_pkg::*;
#(
   parameter int CS_W   = 2,
   parameter int REG_AW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [REG_AW-1:0]     reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic [1:0]            done_set,
   input  logic [1:0]            cmd_open_v,
   output logic [1:0]            win_en,
   output logic [1:0][CS_W-1:0]  win_cs,
   output logic [1:0][7:0]       win_op,
   output logic [1:0][31:0]      win_cfg,
   output logic [1:0][31:0]      win_base,
   output logic [1:0][31:0]      win_range,
   output logic [1:0]            term_pulse
);
   logic [1:0][31:0] cfg_q, ctrl_q, base_q, range_q;
   logic [1:0]       sts_q;

   logic sts_hit;
   assign sts_hit = reg_we && (reg_addr == REG_AW'(OFF_STATUS));

   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam logic [REG_AW-1:0] A_CFG   = REG_AW'(bank_off(s, ROLE_CFG));
      localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(bank_off(s, ROLE_CTRL));
      localparam logic [REG_AW-1:0] A_BASE  = REG_AW'(bank_off(s, ROLE_BASE));
      localparam logic [REG_AW-1:0] A_RANGE = REG_AW'(bank_off(s, ROLE_RANGE));
      localparam int STS_BIT = STS_RD_BIT + s;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[s]   <= '0;
            ctrl_q[s]  <= '0;
            base_q[s]  <= '0;
            range_q[s] <= '0;
         end else if (reg_we) begin
            if (reg_addr == A_CFG)   cfg_q[s]   <= reg_wdata;
            if (reg_addr == A_CTRL)  ctrl_q[s]  <= reg_wdata;
            if (reg_addr == A_BASE)  base_q[s]  <= reg_wdata;
            if (reg_addr == A_RANGE) range_q[s] <= reg_wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            sts_q[s] <= 1'b0;
         else if (done_set[s])                  sts_q[s] <= 1'b1;
         else if (sts_hit && reg_wdata[STS_BIT]) sts_q[s] <= 1'b0;
      end

      assign term_pulse[s] = reg_we && (reg_addr == A_CTRL) &&
                             !reg_wdata[CTRL_EN_BIT] && ctrl_q[s][CTRL_EN_BIT];
      assign win_en[s]    = ctrl_q[s][CTRL_EN_BIT];
      assign win_cs[s]    = ctrl_q[s][CTRL_CS_LSB +: CS_W];
      assign win_op[s]    = ctrl_q[s][7:0];
      assign win_base[s]  = base_q[s];
      assign win_range[s] = range_q[s];

      if (s == SIDE_RD) begin : g_dir_rd
         assign win_cfg[s] = cfg_q[s] | (32'd1 << CFG_DIR_BIT);
      end else begin : g_dir_wr
         assign win_cfg[s] = cfg_q[s] & ~(32'd1 << CFG_DIR_BIT);
      end

      AST_FLAG_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sts_q[s]) |-> !cmd_open_v[s]);                           // R9
      AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
         sts_hit && reg_wdata[STS_BIT] && !done_set[s] |=> !sts_q[s]);   // R10
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(OFF_STATUS)) begin
         reg_rdata[STS_RD_BIT]     = sts_q[SIDE_RD];
         reg_rdata[STS_RD_BIT + 1] = sts_q[SIDE_WR];
      end
      for (int s = 0; s < 2; s++) begin
         if (reg_addr == REG_AW'(bank_off(s, ROLE_CFG)))   reg_rdata = cfg_q[s];
         if (reg_addr == REG_AW'(bank_off(s, ROLE_CTRL)))  reg_rdata = ctrl_q[s];
         if (reg_addr == REG_AW'(bank_off(s, ROLE_BASE)))  reg_rdata = base_q[s];
         if (reg_addr == REG_AW'(bank_off(s, ROLE_RANGE))) reg_rdata = range_q[s];
      end
   end
endmodule

// File: rtl/lfw_win_check.sv
module lfw_win_check #(
   parameter int ADDR_W = 32
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] range,
   input  logic [ADDR_W-1:0] off,
   output logic              ok,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W:0] sum;

   assign sum  = {1'b0, base} + {1'b0, off};
   assign addr = sum[ADDR_W-1:0];
   // enabled, inside the programmed range, no carry out of the address
   assign ok   = en && (off < range) && !sum[ADDR_W];
endmodule

// File: rtl/lfw_seq.sv
module lfw_seq
   import lfw_pkg::*;
#(
   parameter int CS_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  win_req,
   input  logic                  win_we,
   input  logic [7:0]            win_wdata,
   output logic                  win_ack,
   output logic                  win_err,
   output logic [7:0]            win_rdata,
   input  logic [1:0]            chk_ok,
   input  logic [1:0][31:0]      chk_addr,
   input  logic [1:0]            term_pulse,
   input  logic [1:0][31:0]      win_cfg,
   input  logic [1:0][CS_W-1:0]  win_cs,
   input  logic [1:0][7:0]       win_op,
   output logic                  cmd_valid,
   input  logic                  cmd_ready,
   output lfw_cmd_e              cmd_kind,
   output logic [31:0]           cmd_cfg,
   output logic [7:0]            cmd_opcode,
   output logic [CS_W-1:0]       cmd_cs,
   output logic [31:0]           cmd_addr,
   output logic [7:0]            cmd_wdata,
   input  logic                  eng_rdata_valid,
   input  logic [7:0]            eng_rdata,
   input  logic                  eng_end_done,
   output logic [1:0]            done_set,
   output logic [1:0]            cmd_open_v
);
   typedef enum logic [2:0] {
      S_IDLE, S_END, S_ENDW, S_START, S_DATA, S_RSP, S_ACK
   } st_e;

   st_e         st;
   logic        acc_side, acc_err, open_q, open_side, end_term, term_side;
   logic [31:0] acc_addr, next_addr;
   logic [7:0]  acc_wdata, rdata_q;
   logic [1:0]  term_pend, term_clr;
   logic        tsel, tsel_open, continues;

   assign tsel      = term_pend[SIDE_RD] ? 1'b0 : 1'b1;
   assign tsel_open = open_q && (open_side == tsel);
   assign continues = open_q && (open_side == win_we) && (chk_addr[win_we] == next_addr);

   always_comb begin
      term_clr = '0;
      if (st == S_IDLE && |term_pend && !tsel_open) term_clr[tsel] = 1'b1;
      if (st == S_ENDW && eng_end_done && end_term) term_clr[term_side] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         acc_side  <= 1'b0;
         acc_err   <= 1'b0;
         acc_addr  <= '0;
         acc_wdata <= '0;
         rdata_q   <= '0;
         open_q    <= 1'b0;
         open_side <= 1'b0;
         next_addr <= '0;
         end_term  <= 1'b0;
         term_side <= 1'b0;
         term_pend <= '0;
         done_set  <= '0;
      end else begin
         term_pend <= (term_pend | term_pulse) & ~term_clr;
         done_set  <= term_clr;
         unique case (st)
            S_IDLE: begin
               if (|term_pend) begin
                  if (tsel_open) begin
                     end_term  <= 1'b1;
                     term_side <= tsel;
                     st        <= S_END;
                  end
               end else if (win_req) begin
                  acc_side  <= win_we;
                  acc_addr  <= chk_addr[win_we];
                  acc_wdata <= win_wdata;
                  acc_err   <= !chk_ok[win_we];
                  end_term  <= 1'b0;
                  if (!chk_ok[win_we])  st <= S_ACK;
                  else if (continues)   st <= S_DATA;
                  else if (open_q)      st <= S_END;
                  else                  st <= S_START;
               end
            end
            S_END:   if (cmd_ready) st <= S_ENDW;
            S_ENDW: begin
               if (eng_end_done) begin
                  open_q <= 1'b0;
                  st     <= end_term ? S_IDLE : S_START;
               end
            end
            S_START: begin
               if (cmd_ready) begin
                  open_q    <= 1'b1;
                  open_side <= acc_side;
                  st        <= S_DATA;
               end
            end
            S_DATA: begin
               if (cmd_ready) begin
                  next_addr <= acc_addr + 32'd1;
                  st        <= acc_side ? S_ACK : S_RSP;
               end
            end
            S_RSP: begin
               if (eng_rdata_valid) begin
                  rdata_q <= eng_rdata;
                  st      <= S_ACK;
               end
            end
            S_ACK:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_valid = (st == S_END) || (st == S_START) || (st == S_DATA);
      unique case (st)
         S_END:   cmd_kind = LFW_CMD_END;
         S_DATA:  cmd_kind = LFW_CMD_DATA;
         default: cmd_kind = LFW_CMD_START;
      endcase
   end

   assign cmd_cfg    = win_cfg[acc_side];
   assign cmd_opcode = win_op[acc_side];
   assign cmd_cs     = win_cs[(st == S_END) ? open_side : acc_side];
   assign cmd_addr   = acc_addr;
   assign cmd_wdata  = acc_wdata;
   assign win_ack    = (st == S_ACK);
   assign win_err    = (st == S_ACK) && acc_err;
   assign win_rdata  = rdata_q;
   assign cmd_open_v = {open_q && open_side, open_q && !open_side};

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_addr)); // R11
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      win_ack |=> !win_ack);                                                    // R12
   AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      win_err |-> !cmd_valid && !$past(cmd_valid));                              // R5
   AST_DATA_IN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_kind == LFW_CMD_DATA |-> $countones(cmd_open_v) == 1);    // R7
   AST_START_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_kind == LFW_CMD_START |-> cmd_open_v == 2'b00);           // R8
endmodule

// File: rtl/flash_linear_window.sv
module flash_linear_window
   import lfw_pkg::*;
#(
   parameter int CS_W   = 2,
   parameter int REG_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              win_req,
   input  logic              win_we,
   input  logic [31:0]       win_off,
   input  logic [7:0]        win_wdata,
   output logic              win_ack,
   output logic              win_err,
   output logic [7:0]        win_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_kind,
   output logic [31:0]       cmd_cfg,
   output logic [7:0]        cmd_opcode,
   output logic [CS_W-1:0]   cmd_cs,
   output logic [31:0]       cmd_addr,
   output logic [7:0]        cmd_wdata,
   input  logic              eng_rdata_valid,
   input  logic [7:0]        eng_rdata,
   input  logic              eng_end_done
);
   if (CS_W < 1 || CTRL_CS_LSB + CS_W > CTRL_EN_BIT) begin : g_bad_cs
      $error("CS_W must leave the chip select field below the enable bit");
   end
   if (REG_AW < 8) begin : g_bad_aw
      $error("REG_AW must cover offsets up to 0x8C");
   end

   logic [1:0]            win_en, term_pulse, done_set, cmd_open_v, chk_ok;
   logic [1:0][CS_W-1:0]  win_cs;
   logic [1:0][7:0]       win_op;
   logic [1:0][31:0]      win_cfg, win_base, win_range, chk_addr;
   lfw_cmd_e              kind;

   lfw_regs #(.CS_W(CS_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_set(done_set),
      .cmd_open_v(cmd_open_v), .win_en(win_en), .win_cs(win_cs),
      .win_op(win_op), .win_cfg(win_cfg), .win_base(win_base),
      .win_range(win_range), .term_pulse(term_pulse)
   );

   for (genvar s = 0; s < 2; s++) begin : g_chk
      lfw_win_check #(.ADDR_W(32)) u_chk (
         .en(win_en[s]), .base(win_base[s]), .range(win_range[s]),
         .off(win_off), .ok(chk_ok[s]), .addr(chk_addr[s])
      );
   end

   lfw_seq #(.CS_W(CS_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .win_req(win_req), .win_we(win_we),
      .win_wdata(win_wdata), .win_ack(win_ack), .win_err(win_err),
      .win_rdata(win_rdata), .chk_ok(chk_ok), .chk_addr(chk_addr),
      .term_pulse(term_pulse), .win_cfg(win_cfg), .win_cs(win_cs),
      .win_op(win_op), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_kind(kind), .cmd_cfg(cmd_cfg), .cmd_opcode(cmd_opcode),
      .cmd_cs(cmd_cs), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .eng_rdata_valid(eng_rdata_valid), .eng_rdata(eng_rdata),
      .eng_end_done(eng_end_done), .done_set(done_set),
      .cmd_open_v(cmd_open_v)
   );

   assign cmd_kind = kind;
endmodule

// File: tb/flash_linear_window_test.sv
module flash_linear_window_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        win_req = 1'b0, win_we = 1'b0;
   logic [31:0] win_off = '0;
   logic [7:0]  win_wdata = '0;
   logic        win_ack, win_err;
   logic [7:0]  win_rdata;
   logic        cmd_valid, cmd_ready;
   logic [1:0]  cmd_kind;
   logic [31:0] cmd_cfg, cmd_addr;
   logic [7:0]  cmd_opcode, cmd_wdata;
   logic [1:0]  cmd_cs;
   logic        eng_rdata_valid, eng_end_done;
   logic [7:0]  eng_rdata;

   int checks = 0, fails = 0, cyc = 0;
   int n_start = 0, n_data = 0, n_end = 0;
   logic [31:0] last_addr = '0, last_cfg = '0;
   logic [7:0]  last_op = '0, last_wd = '0;
   logic [1:0]  last_cs = '0;
   int rsp_cnt = 0, end_cnt = 0, end_delay = 6;
   logic [7:0] rsp_byte = '0;
   bit stall = 1'b0;

   always #4 clk = ~clk;

   flash_linear_window uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_req(win_req),
      .win_we(win_we), .win_off(win_off), .win_wdata(win_wdata),
      .win_ack(win_ack), .win_err(win_err), .win_rdata(win_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
      .cmd_cfg(cmd_cfg), .cmd_opcode(cmd_opcode), .cmd_cs(cmd_cs),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .eng_rdata_valid(eng_rdata_valid), .eng_rdata(eng_rdata),
      .eng_end_done(eng_end_done)
   );

   // transfer engine model
   assign cmd_ready = !stall || (cyc % 3 == 0);
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) begin
         rsp_cnt <= 0; end_cnt <= 0;
         eng_rdata_valid <= 1'b0; eng_end_done <= 1'b0; eng_rdata <= '0;
      end else begin
         eng_rdata_valid <= (rsp_cnt == 1);
         eng_rdata       <= rsp_byte;
         eng_end_done    <= (end_cnt == 1);
         if (rsp_cnt != 0) rsp_cnt <= rsp_cnt - 1;
         if (end_cnt != 0) end_cnt <= end_cnt - 1;
         if (cmd_valid && cmd_ready) begin
            case (cmd_kind)
               2'd0: begin
                  n_start <= n_start + 1; last_addr <= cmd_addr;
                  last_op <= cmd_opcode; last_cs <= cmd_cs; last_cfg <= cmd_cfg;
               end
               2'd1: begin
                  n_data <= n_data + 1;
                  if (cmd_cfg[23]) begin
                     rsp_cnt <= 2; rsp_byte <= cmd_addr[7:0] ^ 8'hA5;
                  end else last_wd <= cmd_wdata;
               end
               default: begin
                  n_end <= n_end + 1; end_cnt <= end_delay;
               end
            endcase
         end
      end
   end

   always @(posedge clk) begin
      if (cyc == 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not complete (actual %0d cycles, expected fewer)", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic win_access(input logic we, input logic [31:0] off, input logic [7:0] wd,
                             output logic err, output logic [7:0] rd);
      int n = 0;
      @(negedge clk); win_we = we; win_off = off; win_wdata = wd; win_req = 1'b1;
      while (!win_ack && n < 300) begin @(negedge clk); n++; end
      err = win_err; rd = win_rdata; win_req = 1'b0;
      check(n < 300, "R12 ack arrives", n, 300);
      @(negedge clk);
      check(win_ack == 1'b0, "R12 ack one cycle", win_ack, 0);
   endtask

   task automatic wait_status(input int bitpos, input int lim, output bit seen);
      logic [31:0] v;
      seen = 1'b0;
      for (int i = 0; i < lim && !seen; i++) begin
         reg_read(8'h04, v);
         seen = v[bitpos];
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      reg_read(8'h04, v); check(v == 0, "R1 status", v, 0);
      reg_read(8'h48, v); check(v == 0, "R1 read ctrl", v, 0);
      check(!cmd_valid && !win_ack, "R1 idle outputs", {cmd_valid, win_ack}, 0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      reg_write(8'h44, 32'h0000_4123); reg_write(8'h4C, 32'h1234_5678);
      reg_write(8'h50, 32'h0000_0ABC); reg_write(8'h84, 32'h0040_00AB);
      reg_write(8'h8C, 32'h0000_0033);
      reg_read(8'h44, v); check(v == 32'h0000_4123, "R2 rd cfg", v, 32'h4123);
      reg_read(8'h4C, v); check(v == 32'h1234_5678, "R2 rd base", v, 32'h1234_5678);
      reg_read(8'h50, v); check(v == 32'h0ABC, "R2 rd range", v, 32'h0ABC);
      reg_read(8'h84, v); check(v == 32'h0040_00AB, "R2 wr ctrl", v, 32'h0040_00AB);
      reg_read(8'h8C, v); check(v == 32'h33, "R2 wr range", v, 32'h33);
   endtask

   task automatic t_read_single();
      logic e; logic [7:0] d; logic [31:0] v;
      reg_write(8'h44, 32'h0000_4000); reg_write(8'h4C, 32'h0000_1000);
      reg_write(8'h50, 32'd16);        reg_write(8'h48, 32'h8020_000B);
      reg_read(8'h48, v); check(v == 32'h8020_000B, "R2 ctrl enable readback", v, 32'h8020_000B);
      win_access(1'b0, 32'd3, 8'h00, e, d);
      check(!e && d == 8'hA6, "R3 read byte", {e, d}, 8'hA6);
      check(n_start == 1 && last_addr == 32'h1003, "R3 start address", last_addr, 32'h1003);
      check(last_op == 8'h0B && last_cs == 2'd1, "R3 opcode and cs", {last_op, last_cs}, {8'h0B, 2'd1});
      check(last_cfg == 32'h0080_4000, "R4 read cfg dir bit", last_cfg, 32'h0080_4000);
   endtask

   task automatic t_continue();
      logic e; logic [7:0] d;
      win_access(1'b0, 32'd4, 8'h00, e, d);
      check(!e && d == 8'hA1, "R7 continued byte", d, 8'hA1);
      check(n_start == 1 && n_end == 0 && n_data == 2, "R7 no new start", n_start, 1);
   endtask

   task automatic t_discont();
      logic e; logic [7:0] d;
      win_access(1'b0, 32'd2, 8'h00, e, d);
      check(n_end == 1 && n_start == 2, "R8 close then restart", {n_end[15:0], n_start[15:0]}, {16'd1, 16'd2});
      check(last_addr == 32'h1002 && d == 8'hA7, "R8 new address", last_addr, 32'h1002);
   endtask

   task automatic t_range();
      logic e; logic [7:0] d; int s0, e0, d0;
      s0 = n_start; e0 = n_end; d0 = n_data;
      win_access(1'b0, 32'd16, 8'h00, e, d);
      check(e == 1'b1, "R5 offset at range errors", e, 1);
      check(n_start == s0 && n_end == e0 && n_data == d0, "R5 no command", n_start, s0);
      win_access(1'b0, 32'd15, 8'h00, e, d);
      check(!e && d == (8'h0F ^ 8'hA5), "R5 last offset accepted", d, 8'h0F ^ 8'hA5);
   endtask

   task automatic t_write();
      logic e; logic [7:0] d; int e0;
      e0 = n_end;
      reg_write(8'h80, 32'h0080_0400); reg_write(8'h88, 32'h0000_2000);
      reg_write(8'h8C, 32'd8);         reg_write(8'h84, 32'h8040_0002);
      win_access(1'b1, 32'd0, 8'h77, e, d);
      check(!e && last_wd == 8'h77, "R3 write byte", last_wd, 8'h77);
      check(last_addr == 32'h2000 && last_cs == 2'd2 && last_op == 8'h02, "R3 write start", last_addr, 32'h2000);
      check(last_cfg == 32'h0000_0400, "R4 write cfg dir bit", last_cfg, 32'h0000_0400);
      check(n_end == e0 + 1, "R8 side change closes", n_end, e0 + 1);
   endtask

   task automatic t_overflow();
      logic e; logic [7:0] d; int s0;
      reg_write(8'h4C, 32'hFFFF_FFF0); reg_write(8'h50, 32'h100);
      s0 = n_start;
      win_access(1'b0, 32'h20, 8'h00, e, d);
      check(e && n_start == s0, "R6 overflow rejected", {e, n_start[7:0]}, {1'b1, s0[7:0]});
      win_access(1'b0, 32'h0F, 8'h00, e, d);
      check(!e && last_addr == 32'hFFFF_FFFF && d == 8'h5A, "R6 top address accepted", last_addr, 32'hFFFF_FFFF);
   endtask

   task automatic t_stall();
      logic e; logic [7:0] d;
      stall = 1'b1;
      win_access(1'b0, 32'h0E, 8'h00, e, d);
      stall = 1'b0;
      check(!e && d == 8'h5B && last_addr == 32'hFFFF_FFFE, "R11 stalled read", d, 8'h5B);
   endtask

   task automatic t_term_open();
      logic [31:0] v; bit seen; int e0;
      e0 = n_end;
      reg_write(8'h48, 32'h0020_000B);
      reg_read(8'h04, v);
      check(v[11] == 1'b0, "R9 flag waits for close", v[11], 0);
      wait_status(11, 40, seen);
      check(seen, "R9 read flag set", seen, 1);
      check(n_end == e0 + 1, "R9 open command closed", n_end, e0 + 1);
      reg_write(8'h04, 32'h0000_0000);
      reg_read(8'h04, v); check(v[11] == 1'b1, "R10 write zero keeps", v, 32'h800);
      reg_write(8'h04, 32'h0000_0800);
      reg_read(8'h04, v); check(v == 32'h0, "R10 write one clears", v, 0);
   endtask

   task automatic t_term_closed();
      logic [31:0] v; bit seen; logic e; logic [7:0] d; int s0;
      reg_write(8'h84, 32'h0040_0002);
      wait_status(12, 4, seen);
      check(seen, "R9 idle write flag prompt", seen, 1);
      reg_read(8'h04, v); check(v == 32'h1000, "R9 only write flag", v, 32'h1000);
      s0 = n_start;
      win_access(1'b1, 32'd1, 8'h11, e, d);
      check(e && n_start == s0, "R5 disabled window errors", e, 1);
      win_access(1'b0, 32'd1, 8'h00, e, d);
      check(e == 1'b1, "R5 disabled read window errors", e, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_read_single();
      t_continue();
      t_discont();
      t_range();
      t_write();
      t_overflow();
      t_stall();
      t_term_open();
      t_term_closed();
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule